// File: doc/BRIEF.md
# Hexagonal binary relaxation array

This block is a two-dimensional array of identical programmable boolean cells laid out on a hexagonal grid. The default size is 16 columns by 12 rows. Every cell has six neighbours. Each cell takes two binary inputs: its own pattern bit, and a neighbour bit. The neighbour bit is the OR of the propagation outputs of its six neighbours, its own gate-pattern bit, and the margin value for each neighbour position that falls outside the array. From these two inputs the cell produces a result bit and a propagation bit, and both are chosen from any truth table by an 8-bit function word.

A start pulse latches the pattern, the gate pattern, the margin value and the function word. The array then relaxes synchronously: once per clock, every propagation bit is recomputed from the previous step's values. The run ends when a step changes no propagation bit. The result plane is then registered and `done` pulses. A function that keeps toggling ends after a fixed step budget with the `unstable` flag raised.

Depending on the function word, the array does several jobs:
- per-cell logic between the two stored patterns;
- local neighbourhood features such as edges and isolated cells;
- whole-array connectivity labelling, seeded from the margin or from the gate pattern.

Top module: `hex_relax_array`

## Requirements
- R1: After reset, `busy`, `done` and `unstable` are 0 and `result` is all zeros.
- R2: Cell (r,c) has bit index r*W+c. Its neighbours are (r,c-1) and (r,c+1). On an even row, they also include columns c-1 and c of rows r-1 and r+1. On an odd row, they also include columns c and c+1 of rows r-1 and r+1. The cell's neighbour bit is the OR of those neighbours' propagation bits, its own `gate_in` bit, and `margin_in` for each neighbour that lies outside the array.
- R3: The propagation bit of a cell is `func_in[2*A0+An]`, where A0 is the cell's pattern bit and An is its neighbour bit.
- R4: The result bit of a cell is `func_in[4+2*A0+An]`, evaluated on the final step.
- R5: A run starts with all propagation bits 0. Let k be the first step (counting from 1) whose recomputation changes no propagation bit. Then `done` is high in the clock cycle k cycles after the one in which `start` was sampled, with `unstable` 0.
- R6: Suppose MAX_STEPS steps pass and every one of them changes some propagation bit. Then `done` rises MAX_STEPS cycles after the start cycle. At the same moment `unstable` rises, and `result` holds the result bits of the final step.
- R7: Pattern, gate, margin and function inputs are sampled only by a `start` accepted while idle. Input changes during a run have no effect, and so does a `start` during a run.
- R8: `done` is a single-cycle pulse. `result` and `unstable` hold their values until the next accepted start.
- R9: With propagation bits forced to 0, `gate_in` acts as the second operand of a per-cell two-input function. A gate bit set on a cell seeds propagation, so a function that passes the neighbour bit through black cells labels only the objects it touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| pat_in | input | W*H | Pattern plane, bit r*W+c |
| gate_in | input | W*H | Gate/label plane, bit r*W+c |
| margin_in | input | 1 | Value of out-of-array neighbours |
| func_in | input | 8 | [3:0] propagation truth table, [7:4] result truth table |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| unstable | output | 1 | Run ended without settling |
| result | output | W*H | Result plane |

## Verification
The bench places a single black cell on an even row and another on an odd row, and expects exactly their six neighbours back. A wrong column offset for either row parity would flag the wrong cells. An empty plane with the margin set must light exactly the border columns and rows; a design that fed the margin into interior cells, or missed one border side, would differ there. A label seeded on one ring must select that ring but not the detached nucleus inside it; a design that sped up propagation or failed to bound it would change either the shape or the reported latency. A toggling function must run for exactly the step budget and report `unstable`; inputs scrambled mid-run and a stray start must leave the result unchanged, which catches a design that samples inputs continuously.

// File: rtl/hex_relax_array.sv
module hex_relax_array #(
  parameter int W = 16,
  parameter int H = 12,
  parameter int MAX_STEPS = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W*H-1:0]   pat_in,
  input  logic [W*H-1:0]   gate_in,
  input  logic             margin_in,
  input  logic [7:0]       func_in,
  output logic             busy,
  output logic             done,
  output logic             unstable,
  output logic [W*H-1:0]   result
);
  localparam int N  = W * H;
  localparam int CW = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;

  logic [N-1:0]  a0_q, g_q, prop, nxt, outv, an;
  logic          b_q;
  logic [7:0]    fn_q;
  logic [CW-1:0] cnt;

  for (genvar r = 0; r < H; r++) begin : g_row
    for (genvar c = 0; c < W; c++) begin : g_col
      localparam int I = r * W + c;
      logic [5:0] nb;
      for (genvar k = 0; k < 6; k++) begin : g_nb
        localparam int RR = r + ((k < 2) ? 0 : (k < 4) ? -1 : 1);
        localparam int CC = (k == 0) ? c - 1 :
                            (k == 1) ? c + 1 :
                            c + ((r % 2 == 0) ? -1 : 0) + (k % 2);
        localparam bit OK = (RR >= 0) && (RR < H) && (CC >= 0) && (CC < W);
        localparam int IX = OK ? RR * W + CC : 0;
        assign nb[k] = OK ? prop[IX] : b_q;
      end
      assign an[I]   = (|nb) | g_q[I];
      assign nxt[I]  = fn_q[{1'b0, a0_q[I], an[I]}];
      assign outv[I] = fn_q[{1'b1, a0_q[I], an[I]}];
    end
  end

  wire settled = (nxt == prop);
  wire last    = (cnt == CW'(MAX_STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      unstable <= 1'b0;
      result   <= '0;
      prop     <= '0;
      cnt      <= '0;
      a0_q     <= '0;
      g_q      <= '0;
      b_q      <= 1'b0;
      fn_q     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          a0_q     <= pat_in;
          g_q      <= gate_in;
          b_q      <= margin_in;
          fn_q     <= func_in;
          prop     <= '0;
          cnt      <= '0;
          unstable <= 1'b0;
          busy     <= 1'b1;
        end
      end else if (settled || last) begin
        result   <= outv;
        unstable <= !settled;
        done     <= 1'b1;
        busy     <= 1'b0;
      end else begin
        prop <= nxt;
        cnt  <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hex_relax_array_chk.sv
module hex_relax_array_chk #(
  parameter int N = 192,
  parameter int MAX_STEPS = 192
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         unstable,
  input logic [N-1:0] result
);
  int busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  a_r6_unstable_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unstable) |-> done);
  a_r6_bounded_run: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= MAX_STEPS);
  a_r7_start_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind hex_relax_array hex_relax_array_chk #(.N(W*H), .MAX_STEPS(MAX_STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .unstable(unstable), .result(result)
);

// File: tb/hex_relax_array_bench.sv
module hex_relax_array_bench;
  localparam int W = 16, H = 12, N = W * H, STEPS = 192;

  logic clk = 0, rst_n = 0, start = 0, margin_in = 0;
  logic [N-1:0] pat_in = '0, gate_in = '0;
  logic [7:0] func_in = '0;
  logic busy, done, unstable;
  logic [N-1:0] result;

  hex_relax_array #(.W(W), .H(H), .MAX_STEPS(STEPS)) u_hex_relax_array (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_in(pat_in), .gate_in(gate_in),
    .margin_in(margin_in), .func_in(func_in), .busy(busy), .done(done),
    .unstable(unstable), .result(result));

  always #10 clk = ~clk;

  typedef struct { logic [N-1:0] res; bit un; int lat; int c0; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ix(int r, int c); return r * W + c; endfunction

  function automatic void model(input logic [N-1:0] a, g, input bit b, input logic [7:0] f,
                                output logic [N-1:0] res, output bit un, output int n);
    logic [N-1:0] p, np, o;
    p = '0; res = '0; un = 0; n = 0;
    for (int s = 0; s < STEPS; s++) begin
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) begin
          bit an;
          int sh;
          an = g[ix(r, c)];
          sh = (r % 2 == 0) ? -1 : 0;
          for (int k = 0; k < 6; k++) begin
            int rr, cc;
            case (k)
              0: begin rr = r; cc = c - 1; end
              1: begin rr = r; cc = c + 1; end
              2: begin rr = r - 1; cc = c + sh; end
              3: begin rr = r - 1; cc = c + sh + 1; end
              4: begin rr = r + 1; cc = c + sh; end
              default: begin rr = r + 1; cc = c + sh + 1; end
            endcase
            if (rr < 0 || rr >= H || cc < 0 || cc >= W) an = an | b;
            else an = an | p[ix(rr, cc)];
          end
          np[ix(r, c)] = f[2 * a[ix(r, c)] + an];
          o[ix(r, c)]  = f[4 + 2 * a[ix(r, c)] + an];
        end
      if (np == p) begin res = o; un = 0; n = s + 1; return; end
      if (s == STEPS - 1) begin res = o; un = 1; n = STEPS; return; end
      p = np;
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input logic [N-1:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      item_t it;
      if (q.size() == 0) check(0, "R5", "done with empty scoreboard", '0, '0);
      else begin
        it = q.pop_front();
        check(result == it.res, it.tag, "result", result, it.res);
        check(unstable == it.un, it.tag, "unstable", N'(unstable), N'(it.un));
        check(cyc - it.c0 == it.lat + 1, it.tag, "latency", N'(cyc - it.c0), N'(it.lat + 1));
      end
    end
  end

  task automatic run_case(input logic [N-1:0] a, g, input bit b, input logic [7:0] f,
                          input bit use_exp, input logic [N-1:0] xres, input bit scramble,
                          input string tag);
    item_t it;
    logic [N-1:0] mres;
    bit mun;
    int n;
    model(a, g, b, f, mres, mun, n);
    it.res = use_exp ? xres : mres;
    it.un = mun; it.lat = n; it.tag = tag;
    @(negedge clk);
    pat_in = a; gate_in = g; margin_in = b; func_in = f; start = 1;
    it.c0 = cyc;
    q.push_back(it);
    @(negedge clk);
    start = 0;
    if (scramble) begin
      pat_in = ~a; gate_in = {6{$urandom()}}; margin_in = ~b; func_in = ~f; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 0, "R8", "done pulse width", N'(done), '0);
    repeat (3) @(negedge clk);
    check(result == it.res, "R8", "result hold", result, it.res);
    check(unstable == it.un, "R8", "unstable hold", N'(unstable), N'(it.un));
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    check(0, "R5", "watchdog expired", '0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] a, g, e;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && unstable == 0, "R1", "status at reset", N'({busy, done, unstable}), '0);
    check(result == '0, "R1", "result at reset", result, '0);
    rst_n = 1;

    // R2 six neighbours, odd and even rows: prop = A0, result = !A0 & An
    a = '0; a[ix(5, 5)] = 1; a[ix(4, 11)] = 1;
    e = '0;
    e[ix(5, 4)] = 1; e[ix(5, 6)] = 1; e[ix(4, 5)] = 1; e[ix(4, 6)] = 1; e[ix(6, 5)] = 1; e[ix(6, 6)] = 1;
    e[ix(4, 10)] = 1; e[ix(4, 12)] = 1; e[ix(3, 10)] = 1; e[ix(3, 11)] = 1; e[ix(5, 10)] = 1; e[ix(5, 11)] = 1;
    run_case(a, '0, 0, 8'b0010_1100, 1, e, 0, "R2");

    // R2 margin reaches only border cells: result = An, prop 0
    e = '0;
    for (int r = 0; r < H; r++) for (int c = 0; c < W; c++)
      if (r == 0 || r == H - 1 || c == 0 || c == W - 1) e[ix(r, c)] = 1;
    run_case('0, '0, 1, 8'b1010_0000, 1, e, 0, "R2");
    run_case('0, '0, 0, 8'b1010_0000, 1, '0, 0, "R2");

    // R9 pattern comparison: result = A0 | G, settles in one step (R5)
    a = {6{32'h1234_5678}}; g = {6{32'h0F0F_00FF}};
    run_case(a, g, 0, 8'b1110_0000, 1, a | g, 0, "R9");
    run_case(a, g, 0, 8'b1000_0000, 1, a & g, 0, "R4");

    // ring with a nucleus and a speck
    a = '0;
    for (int c = 3; c <= 10; c++) begin a[ix(2, c)] = 1; a[ix(8, c)] = 1; end
    for (int r = 2; r <= 8; r++) begin a[ix(r, 3)] = 1; a[ix(r, 10)] = 1; end
    a[ix(5, 6)] = 1; a[ix(5, 7)] = 1; a[ix(10, 1)] = 1;

    // R3 edge detection: prop = !A0, result = A0 & An
    run_case(a, '0, 0, 8'b1000_0011, 0, '0, 0, "R3");
    // R3 outer edge from margin: prop = !A0 & An, result = A0 & An
    run_case(a, '0, 1, 8'b1000_0010, 0, '0, 0, "R3");

    // R9 labelling seeded at a ring cell: ring selected, nucleus and speck not
    g = '0; g[ix(2, 3)] = 1;
    e = a; e[ix(5, 6)] = 0; e[ix(5, 7)] = 0; e[ix(10, 1)] = 0;
    run_case(a, g, 0, 8'b1000_1000, 1, e, 0, "R9");
    // R7 same run with inputs scrambled and start pulsed mid-run
    run_case(a, g, 0, 8'b1000_1000, 1, e, 1, "R7");

    // R6 oscillation: prop = !An, result = An; final step has all prop high
    run_case(a, '0, 0, 8'b1010_0101, 1, '1, 0, "R6");

    // R5 assorted planes and functions against the relaxation rules
    for (int t = 0; t < 6; t++) begin
      logic [7:0] f;
      a = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
      g = (t % 2) ? {$urandom() & $urandom(), 160'b0} : '0;
      case (t % 3)
        0: f = 8'b1000_1000;
        1: f = 8'b0100_0010;
        default: f = 8'b0110_1100;
      endcase
      run_case(a, g, t[1], f, 0, '0, 0, "R5");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule